// File: doc/BRIEF.md
# Yield-Point Interrupt Dispatcher

This block chooses the next program-counter value for a small 8-bit core that accepts interrupts only at explicit yield points. The core raises `yield_pulse` when a return-from-interrupt or a poll instruction retires. At that moment the dispatcher looks at its synchronised interrupt request lines. The lowest-numbered pending line wins. If no line is pending, the main-program pseudo-interrupt is chosen instead, unless the main mask is set. With the mask set and nothing pending, the core goes to sleep until a request line rises.

Every dispatch is a single-cycle pulse. The pulse carries the entry address and a 4-bit source code, and it raises a clear-registers strobe for the core's datapath. The dispatcher holds the main mask flag. A block strobe sets the flag, and every dispatch clears it. After reset, the first dispatch goes to the power-up entry.

Top module: `yield_dispatch`

## Requirements
- R1: Request lines are acted on only at a yield pulse, at power-up, or while asleep. A pending request with no yield pulse causes no dispatch.
- R2: When several lines are pending at a yield, the line with the lowest index is dispatched.
- R3: The entry address for line n is 0xFC00 + 64·n, and the source code is n. For example, line 13 enters at 0xFF40.
- R4: A yield with no pending line and the mask set dispatches nothing and raises `sleeping` on the next cycle. Further yield pulses while asleep are ignored.
- R5: While asleep, a request line that goes high before clock edge k produces a dispatch visible after edge k+2. This is two synchroniser stages plus one output register. `sleeping` falls with that dispatch.
- R6: `disp_valid` and `clear_regs` are high together for exactly one cycle per dispatch, and `mask_flag` reads 0 in that cycle.
- R7: A `mask_set` pulse sets `mask_flag` to 1 unless a dispatch happens on the same edge. A `mask_set` in the same cycle as a yield counts as already set for that yield.
- R8: The number of request lines is a parameter from 1 to 14. Only the lines that exist are decoded.
- R9: During reset all outputs are 0. On the first edge after reset is released, a dispatch to 0xFFC0 with source code 15 is issued.
- R10: A yield with no pending line and the mask clear dispatches to 0xFF80 with source code 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| irq_req | input | NUM_IRQ | Level-sensitive request lines, line 0 highest priority |
| yield_pulse | input | 1 | Return or poll instruction has retired |
| mask_set | input | 1 | Block strobe, sets the main mask |
| disp_valid | output | 1 | One-cycle dispatch pulse |
| disp_pc | output | 16 | New program counter |
| disp_src | output | 4 | Source: 0..13 line, 14 main program, 15 power-up |
| clear_regs | output | 1 | Clear accumulator, index, word register and flags |
| sleeping | output | 1 | Low-power wait |
| mask_flag | output | 1 | Current main mask |

## Verification
The bench sweeps every one of the 16384 request patterns through a yield and checks that the lowest set bit wins. A reversed or off-by-one encoder would fail on most multi-bit patterns. A wrong address formula would fail on single lines. The bench holds a request with no yield and watches for a premature dispatch. It also counts the exact wake latency from sleep, so a missing or extra synchroniser stage shows up as a one-cycle shift. It checks that yields are ignored while asleep, and that a block strobe on the same cycle as the yield still forces sleep. A design that read the old mask value there would dispatch the main program instead. A three-line instance confirms that the parameter narrows decoding.

// File: rtl/yield_dispatch.sv
module yield_dispatch #(
  parameter int          NUM_IRQ    = 14,
  parameter logic [15:0] IRQ_BASE   = 16'hFC00,
  parameter int          STRIDE_LG2 = 6,
  parameter logic [15:0] MAIN_VEC   = 16'hFF80,
  parameter logic [15:0] BOOT_VEC   = 16'hFFC0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic               yield_pulse,
  input  logic               mask_set,
  output logic               disp_valid,
  output logic [15:0]        disp_pc,
  output logic [3:0]         disp_src,
  output logic               clear_regs,
  output logic               sleeping,
  output logic               mask_flag
);
  localparam logic [3:0] SRC_MAIN = 4'd14;
  localparam logic [3:0] SRC_BOOT = 4'd15;

  logic [NUM_IRQ-1:0] sync1, sync2;
  logic boot, asleep, mflag;
  logic [3:0] win;
  logic any_irq, m_eff, take, go_sleep;
  logic [15:0] next_pc;
  logic [3:0] next_src;

  always_comb begin
    win = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--)
      if (sync2[i]) win = 4'(i);
  end

  assign any_irq  = |sync2;
  assign m_eff    = mflag | mask_set;
  assign take     = boot | (asleep & any_irq) | (!asleep & yield_pulse & (any_irq | !m_eff));
  assign go_sleep = !boot & !asleep & yield_pulse & !any_irq & m_eff;
  assign next_src = boot ? SRC_BOOT : (any_irq ? win : SRC_MAIN);
  assign next_pc  = boot ? BOOT_VEC :
                    (any_irq ? IRQ_BASE + (16'(win) << STRIDE_LG2) : MAIN_VEC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1      <= '0;
      sync2      <= '0;
      boot       <= 1'b1;
      asleep     <= 1'b0;
      mflag      <= 1'b0;
      disp_valid <= 1'b0;
      disp_pc    <= '0;
      disp_src   <= '0;
    end else begin
      sync1      <= irq_req;
      sync2      <= sync1;
      boot       <= 1'b0;
      disp_valid <= take;
      if (take) begin
        disp_pc  <= next_pc;
        disp_src <= next_src;
        mflag    <= 1'b0;
        asleep   <= 1'b0;
      end else begin
        if (mask_set) mflag  <= 1'b1;
        if (go_sleep) asleep <= 1'b1;
      end
    end
  end

  assign clear_regs = disp_valid;
  assign sleeping   = asleep;
  assign mask_flag  = mflag;

  p_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> ($past(yield_pulse) || $past(sleeping) || $past(boot)));
  p_vec_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (disp_pc[15:10] == 6'b111111 && disp_pc[5:0] == 6'd0));
  p_sleep_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleeping) |-> mask_flag && !disp_valid);
  p_mask_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> !mask_flag && !sleeping);
  p_blk_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mask_set |=> (mask_flag || disp_valid));
  p_boot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(boot) |-> disp_valid && disp_src == SRC_BOOT);
endmodule

// File: tb/yield_dispatch_tb.sv
`timescale 1ns/1ps
module yield_dispatch_tb;
  logic clk = 0, rst_n = 0;
  logic [13:0] irq = '0;
  logic yield = 0, mset = 0;
  logic dv, cr, sl, mf;
  logic [15:0] pc;
  logic [3:0] src;
  logic [2:0] irq3 = '0;
  logic yield3 = 0;
  logic dv3, cr3, sl3, mf3;
  logic [15:0] pc3;
  logic [3:0] src3;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  yield_dispatch u_dut (.clk(clk), .rst_n(rst_n), .irq_req(irq), .yield_pulse(yield),
    .mask_set(mset), .disp_valid(dv), .disp_pc(pc), .disp_src(src), .clear_regs(cr),
    .sleeping(sl), .mask_flag(mf));

  yield_dispatch #(.NUM_IRQ(3)) u_dut3 (.clk(clk), .rst_n(rst_n), .irq_req(irq3),
    .yield_pulse(yield3), .mask_set(1'b0), .disp_valid(dv3), .disp_pc(pc3),
    .disp_src(src3), .clear_regs(cr3), .sleeping(sl3), .mask_flag(mf3));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] expect_of(input logic [13:0] p);
    for (int i = 0; i < 14; i++)
      if (p[i]) return {16'hFC00 + 16'(i * 64), 4'(i)};
    return {16'hFF80, 4'd14};
  endfunction

  task automatic do_yield();
    yield = 1; @(negedge clk); yield = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset outputs", {dv, cr, sl, mf, pc, src}, '0);
    rst_n = 1;
    @(negedge clk);
    chk("R9 boot dispatch", {dv, cr, pc, src}, {1'b1, 1'b1, 16'hFFC0, 4'd15});
    chk("R8 small boot", {dv3, pc3, src3}, {1'b1, 16'hFFC0, 4'd15});
    @(negedge clk);
    chk("R6 one cycle", {dv, cr}, 2'b00);

    // R1: pending line without a yield
    irq = 14'h0004;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk("R1 no yield no dispatch", dv, 0);
    end
    irq = '0;
    repeat (3) @(negedge clk);

    // R2 R3 R10: full sweep of request patterns
    for (int p = 0; p < 16384; p++) begin
      irq = 14'(p);
      repeat (3) @(negedge clk);
      do_yield();
      if (p == 0) chk("R10 main entry", {dv, pc, src}, {1'b1, expect_of(14'(p))});
      else        chk("R2 R3 priority and vector", {dv, pc, src}, {1'b1, expect_of(14'(p))});
      chk("R6 strobe and mask", {cr, mf}, 2'b10);
    end
    irq = '0;
    repeat (3) @(negedge clk);

    // R7 R4 R5: mask, sleep, wake
    mset = 1; @(negedge clk); mset = 0;
    chk("R7 mask set", mf, 1);
    do_yield();
    chk("R4 sleeping", {sl, dv}, 2'b10);
    do_yield();
    chk("R4 yield ignored asleep", {sl, dv}, 2'b10);
    irq = 14'h0020;
    repeat (2) @(negedge clk);
    chk("R5 not yet awake", {sl, dv}, 2'b10);
    @(negedge clk);
    chk("R5 wake dispatch", {dv, sl, mf, pc, src}, {3'b100, 16'hFD40, 4'd5});
    irq = '0;
    repeat (3) @(negedge clk);
    do_yield();
    chk("R10 after wake", {dv, pc, src}, {1'b1, 16'hFF80, 4'd14});

    // R7: mask_set in the same cycle as the yield
    @(negedge clk);
    mset = 1; yield = 1; @(negedge clk); mset = 0; yield = 0;
    chk("R7 same-cycle mask sleeps", {sl, dv, mf}, 3'b101);
    irq = 14'h2000;
    repeat (3) @(negedge clk);
    chk("R5 wake line 13", {dv, sl, pc, src}, {2'b10, 16'hFF40, 4'd13});
    // R7: mask does not block a pending line
    repeat (2) @(negedge clk);
    mset = 1; @(negedge clk); mset = 0;
    do_yield();
    chk("R7 mask leaves lines live", {dv, pc, src}, {1'b1, 16'hFF40, 4'd13});
    irq = '0;

    // R8: three-line instance
    for (int p = 0; p < 8; p++) begin
      irq3 = 3'(p);
      repeat (3) @(negedge clk);
      yield3 = 1; @(negedge clk); yield3 = 0;
      chk("R8 three lines", {dv3, pc3, src3}, {1'b1, expect_of(14'(p))});
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule